// File: doc/BRIEF.md
# Segmented Charge-Pump Switch Controller

This block is the digital control core of a switched-capacitor step-down converter. It receives a charge-rate strobe and a handful of comparator and protection flags. From these it drives the gate enables of the four power switches. Each switch is built from three segments: two quarter-size slices and one half-size slice. The block regulates by hysteretic pulse skipping. When the output rises above its upper limit, every switch turns off until the output falls below its lower limit. Switching then resumes at reduced strength, and more segments are added if regulation takes too many charge cycles.

A mode selector picks between halving operation (2:1) and pass-through operation (1:1). The selector follows the input-voltage flag, but a change takes effect only at the start of a charging phase. The two switching phases are separated by a programmable gap in which nothing conducts. Enable and the protection flags override everything else. All control pins are plain levels or single-cycle pulses. There is no handshake, so the strobe and the flags are taken as they are presented on each clock.

Top module: `cp_switch_ctrl`

## Requirements
- R1: When `en` is low, or `short_flt` or `ot_flt` is high, all gate outputs are zero from the next clock onward.
- R2: When `above_hi` is sampled high, all gate outputs are zero from the next clock. They stay zero, whatever `chg_tick` does, until `below_lo` is sampled high.
- R3: Resuming from a skip starts phase A on the next clock with only the `gate_q0` slices active. A `gate_q1` or `gate_hf` bit is only ever set where the matching `gate_q0` bit is set.
- R4: A charge cycle is one phase A followed by one phase B, and it completes when phase B ends. After `QTR_CYC` (default 3) cycles complete at quarter strength without a skip, `gate_q1` is added alongside `gate_q0`.
- R5: After a further `HALF_CYC` (default 7) completed cycles at half strength, `gate_hf` is added, giving full strength.
- R6: A start-up runs at full strength from the first phase until the first skip. A start-up is the first run after `en` rises, after reset, or after a fault clears.
- R7: In 2:1 mode, phase A drives switches 1 and 3 and phase B drives switches 2 and 4. Bit i of each gate vector is switch i+1, so the phase A pattern is 4'b0101 and the phase B pattern is 4'b1010.
- R8: In 1:1 mode, switch 3 is never driven. Phase A drives switches 1 and 4 (4'b1001) and phase B drives switches 2 and 4 (4'b1010).
- R9: `vin_hi` high selects 2:1 mode and low selects 1:1 mode. The value is captured only when phase A begins, so a change during a phase leaves that phase's pattern unchanged.
- R10: A `chg_tick` pulse ends the current phase. Exactly `DEAD` clocks with every gate low then follow before the other phase starts, so the two phases never overlap.
- R11: The completed-cycle counter saturates. Full strength holds for any number of further charge cycles until the next skip.
- R12: If `above_hi` and `below_lo` are both high, `above_hi` wins and the switches stay off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| chg_tick | input | 1 | One-clock strobe that ends the current switching phase |
| above_hi | input | 1 | Output is above its upper regulation limit |
| below_lo | input | 1 | Output is below its lower regulation limit |
| vin_hi | input | 1 | Input is above the 2:1 threshold |
| short_flt | input | 1 | Output short detected |
| ot_flt | input | 1 | Over-temperature detected |
| gate_q0 | output | 4 | First quarter-slice enable, one bit per switch |
| gate_q1 | output | 4 | Second quarter-slice enable, one bit per switch |
| gate_hf | output | 4 | Half-slice enable, one bit per switch |

## Verification
The assertions check on every clock that:
- protection and skip requests blank the gates one clock later;
- switches 1 and 2, and switches 3 and 4, are never on together;
- the slices stay nested;
- a resume comes back at quarter strength;
- a start-up comes back at full strength.

The escalation count, the exact gap length, the point at which the mode is captured, and counter saturation only show over long runs of charge cycles. The bench covers these by walking every phase of every run in both modes. It compares each sample with a pattern computed from the number of completed cycles.

// File: rtl/cpsc_pkg.sv
package cpsc_pkg;
  localparam int NUM_SW = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_A    = 2'd1,
    PH_B    = 2'd2,
    PH_GAP  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    LV_QTR  = 2'd0,
    LV_HALF = 2'd1,
    LV_FULL = 2'd2
  } level_e;

  typedef enum logic [1:0] {
    RS_OFF  = 2'd0,
    RS_SKIP = 2'd1,
    RS_RUN  = 2'd2
  } run_e;
endpackage

// File: rtl/cpsc_phase_seq.sv
module cpsc_phase_seq
  import cpsc_pkg::*;
#(
  parameter int DEAD = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   halt,
  input  logic   go,
  input  logic   tick,
  input  logic   vin_hi,
  output phase_e phase,
  output logic   mode21,
  output logic   b_end
);
  localparam int DW = (DEAD > 1) ? $clog2(DEAD) : 1;

  phase_e        phase_q;
  logic          to_b_q;
  logic [DW-1:0] dcnt_q;
  logic          mode_q;

  assign phase  = phase_q;
  assign mode21 = mode_q;
  assign b_end  = !halt && !go && tick && (phase_q == PH_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      to_b_q  <= 1'b0;
      dcnt_q  <= '0;
      mode_q  <= 1'b0;
    end else if (halt) begin
      phase_q <= PH_IDLE;
      dcnt_q  <= '0;
    end else if (go) begin
      phase_q <= PH_A;
      mode_q  <= vin_hi;
      dcnt_q  <= '0;
    end else begin
      case (phase_q)
        PH_A: if (tick) begin
          phase_q <= PH_GAP;
          to_b_q  <= 1'b1;
          dcnt_q  <= DW'(DEAD - 1);
        end
        PH_B: if (tick) begin
          phase_q <= PH_GAP;
          to_b_q  <= 1'b0;
          dcnt_q  <= DW'(DEAD - 1);
        end
        PH_GAP: begin
          if (dcnt_q == '0) begin
            phase_q <= to_b_q ? PH_B : PH_A;
            if (!to_b_q) mode_q <= vin_hi;
          end else begin
            dcnt_q <= dcnt_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cpsc_seg_ladder.sv
module cpsc_seg_ladder
  import cpsc_pkg::*;
#(
  parameter int QTR_CYC  = 3,
  parameter int HALF_CYC = 7
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_full,
  input  logic   load_qtr,
  input  logic   b_end,
  output level_e level
);
  localparam int CMAX = QTR_CYC + HALF_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  level_e        level_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign level   = level_q;
  assign cnt_inc = (cnt_q == CW'(CMAX)) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LV_FULL;
      cnt_q   <= '0;
    end else if (load_full) begin
      level_q <= LV_FULL;
      cnt_q   <= '0;
    end else if (load_qtr) begin
      level_q <= LV_QTR;
      cnt_q   <= '0;
    end else if (b_end) begin
      cnt_q <= cnt_inc;
      if (level_q == LV_QTR && cnt_inc >= CW'(QTR_CYC))
        level_q <= LV_HALF;
      else if (level_q == LV_HALF && cnt_inc >= CW'(CMAX))
        level_q <= LV_FULL;
    end
  end
endmodule

// File: rtl/cpsc_gate_map.sv
module cpsc_gate_map
  import cpsc_pkg::*;
(
  input  phase_e            phase,
  input  logic              mode21,
  input  level_e            level,
  output logic [NUM_SW-1:0] q0,
  output logic [NUM_SW-1:0] q1,
  output logic [NUM_SW-1:0] hf
);
  logic [NUM_SW-1:0] sel;
  logic              in_a, in_b;

  assign in_a = (phase == PH_A);
  assign in_b = (phase == PH_B);

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    if (i == 0) begin : g_s1
      assign sel[i] = in_a;
    end else if (i == 1) begin : g_s2
      assign sel[i] = in_b;
    end else if (i == 2) begin : g_s3
      assign sel[i] = in_a && mode21;
    end else begin : g_s4
      assign sel[i] = in_b || (in_a && !mode21);
    end
    assign q0[i] = sel[i];
    assign q1[i] = sel[i] && (level != LV_QTR);
    assign hf[i] = sel[i] && (level == LV_FULL);
  end
endmodule

// File: rtl/cp_switch_ctrl.sv
module cp_switch_ctrl
  import cpsc_pkg::*;
#(
  parameter int DEAD     = 2,
  parameter int QTR_CYC  = 3,
  parameter int HALF_CYC = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       chg_tick,
  input  logic       above_hi,
  input  logic       below_lo,
  input  logic       vin_hi,
  input  logic       short_flt,
  input  logic       ot_flt,
  output logic [3:0] gate_q0,
  output logic [3:0] gate_q1,
  output logic [3:0] gate_hf
);
  run_e   st_q, st_n;
  phase_e phase;
  level_e level;
  logic   mode21, b_end, fault, go, halt, load_full, load_qtr;

  assign fault = !en || short_flt || ot_flt;

  always_comb begin
    st_n = st_q;
    if (fault) st_n = RS_OFF;
    else begin
      case (st_q)
        RS_OFF:  st_n = above_hi ? RS_SKIP : RS_RUN;
        RS_SKIP: st_n = above_hi ? RS_SKIP : (below_lo ? RS_RUN : RS_SKIP);
        RS_RUN:  st_n = above_hi ? RS_SKIP : RS_RUN;
        default: st_n = RS_OFF;
      endcase
    end
  end

  assign halt      = (st_n != RS_RUN);
  assign go        = (st_n == RS_RUN) && (st_q != RS_RUN);
  assign load_full = go && (st_q == RS_OFF);
  assign load_qtr  = go && (st_q == RS_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_OFF;
    else        st_q <= st_n;
  end

  cpsc_phase_seq #(.DEAD(DEAD)) u_phase (
    .clk(clk), .rst_n(rst_n), .halt(halt), .go(go), .tick(chg_tick),
    .vin_hi(vin_hi), .phase(phase), .mode21(mode21), .b_end(b_end)
  );

  cpsc_seg_ladder #(.QTR_CYC(QTR_CYC), .HALF_CYC(HALF_CYC)) u_ladder (
    .clk(clk), .rst_n(rst_n), .load_full(load_full), .load_qtr(load_qtr),
    .b_end(b_end), .level(level)
  );

  cpsc_gate_map u_map (
    .phase(phase), .mode21(mode21), .level(level),
    .q0(gate_q0), .q1(gate_q1), .hf(gate_hf)
  );
endmodule

// File: rtl/cpsc_checker.sv
module cpsc_checker
  import cpsc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       short_flt,
  input logic       ot_flt,
  input logic       above_hi,
  input logic [3:0] q0,
  input logic [3:0] q1,
  input logic [3:0] hf,
  input run_e       st_q
);
  logic [3:0] any_on;
  assign any_on = q0 | q1 | hf;

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || short_flt || ot_flt) |=> (any_on == 4'b0)); // R1
  AST_SKIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    above_hi |=> (any_on == 4'b0)); // R2
  AST_NO_OVERLAP_12: assert property (@(posedge clk) disable iff (!rst_n)
    !(any_on[0] && any_on[1])); // R10
  AST_NO_OVERLAP_34: assert property (@(posedge clk) disable iff (!rst_n)
    !(any_on[2] && any_on[3])); // R7
  AST_SEG_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((q1 & ~q0) == 4'b0) && ((hf & ~q1) == 4'b0)); // R3
  AST_RESUME_QTR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == RS_SKIP && st_q == RS_RUN) |-> (q1 == 4'b0 && hf == 4'b0)); // R3
  AST_START_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == RS_OFF && st_q == RS_RUN) |-> (hf == q0 && q0 != 4'b0)); // R6
endmodule

bind cp_switch_ctrl cpsc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .short_flt(short_flt), .ot_flt(ot_flt),
  .above_hi(above_hi), .q0(gate_q0), .q1(gate_q1), .hf(gate_hf), .st_q(st_q)
);

// File: tb/tb_cp_switch_ctrl.sv
module tb_cp_switch_ctrl;
  localparam int DEAD = 2;
  localparam int TP   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, chg_tick = 1'b0, above_hi = 1'b0, below_lo = 1'b0;
  logic vin_hi = 1'b1, short_flt = 1'b0, ot_flt = 1'b0;
  logic [3:0] gate_q0, gate_q1, gate_hf;
  int nvec = 0, nbad = 0, tcnt = 0;

  always #2 clk = ~clk;

  cp_switch_ctrl #(.DEAD(DEAD), .QTR_CYC(3), .HALF_CYC(7)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .chg_tick(chg_tick),
    .above_hi(above_hi), .below_lo(below_lo), .vin_hi(vin_hi),
    .short_flt(short_flt), .ot_flt(ot_flt),
    .gate_q0(gate_q0), .gate_q1(gate_q1), .gate_hf(gate_hf)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
    chg_tick = (tcnt == TP - 1);
    tcnt = (tcnt == TP - 1) ? 0 : tcnt + 1;
    #1;
  endtask

  function automatic logic [11:0] exp_gates(int ph, bit m21, int lvl);
    logic [3:0] s;
    s = (ph == 1) ? (m21 ? 4'b0101 : 4'b1001) : (ph == 2) ? 4'b1010 : 4'b0000;
    return {(lvl >= 2) ? s : 4'b0, (lvl >= 1) ? s : 4'b0, s};
  endfunction

  function automatic int obs_ph();
    return gate_q0[0] ? 1 : (gate_q0[1] ? 2 : 0);
  endfunction

  task automatic chk(string req, logic [11:0] exp);
    nvec++;
    if ({gate_hf, gate_q1, gate_q0} !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, {gate_hf, gate_q1, gate_q0}, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // walks phases, expecting a level derived from completed charge cycles
  task automatic run_phases(bit m21, bit full, int ncyc, string req);
    int done = 0, prev = 1, zlen = -1, lvl, ph;
    for (int k = 0; k < 4000 && done < ncyc; k++) begin
      ph = obs_ph();
      if (prev == 2 && ph != 2) done++;
      if (ph == 0) zlen = (prev != 0) ? 1 : zlen + 1;
      else if (prev == 0 && zlen >= 0) chk_int("R10 gap", zlen, DEAD);
      lvl = full ? 2 : (done < 3 ? 0 : (done < 10 ? 1 : 2));
      chk(req, exp_gates(ph, m21, lvl));
      prev = ph;
      cyc();
    end
  endtask

  task automatic do_skip();
    above_hi = 1'b1;
    cyc();
    above_hi = 1'b0;
    chk("R2 skip", 12'h000);
    for (int k = 0; k < 20; k++) begin
      cyc();
      chk("R2 hold", 12'h000);
    end
  endtask

  task automatic resume();
    below_lo = 1'b1;
    cyc();
    below_lo = 1'b0;
  endtask

  task automatic fault_case(int which);
    if (which == 0) short_flt = 1'b1;
    else if (which == 1) ot_flt = 1'b1;
    else en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk("R1 fault", 12'h000);
    end
    short_flt = 1'b0; ot_flt = 1'b0; en = 1'b1;
    cyc();
    chk("R6 restart full", exp_gates(1, vin_hi, 2));
  endtask

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    chk("R1 reset", 12'h000);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk("R1 disabled", 12'h000);
    end
    // start-up in 2:1 mode
    en = 1'b1; vin_hi = 1'b1;
    cyc();
    run_phases(1'b1, 1'b1, 4, "R6 R7 startup");
    do_skip();
    // escalation and saturation, 2:1
    resume();
    run_phases(1'b1, 1'b0, 16, "R3 R4 R5 R11 R7");
    do_skip();
    // R12: both flags high stays off
    above_hi = 1'b1; below_lo = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk("R12 priority", 12'h000);
    end
    above_hi = 1'b0; below_lo = 1'b0;
    // 1:1 mode
    vin_hi = 1'b0;
    resume();
    run_phases(1'b0, 1'b0, 13, "R3 R4 R5 R8");
    do_skip();
    // R9: mode change inside phase A waits for next phase A
    resume();
    chk("R9 first A 1:1", exp_gates(1, 1'b0, 0));
    vin_hi = 1'b1;
    for (int k = 0; k < 40 && obs_ph() == 1; k++) begin
      chk("R9 held", exp_gates(1, 1'b0, 0));
      cyc();
    end
    for (int k = 0; k < 40 && obs_ph() != 1; k++) cyc();
    chk("R9 next A 2:1", exp_gates(1, 1'b1, 0));
    // faults and enable
    for (int w = 0; w < 3; w++) begin
      for (int k = 0; k < 5; k++) cyc();
      fault_case(w);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule